// File: doc/BRIEF.md
# Bit Clock and Data Recovery

This block sits after a demodulator's data slicer. It turns an asynchronous, oversampled stream of demodulated bits into a clean data bit and a bit clock derived from that data. The input is sampled at sixteen times the nominal bit rate. A digital phase loop pulls a sample-rate phase counter toward each transition it sees in the stream, so it acquires phase during an alternating 1-0-1-0 training preamble and then follows small errors in the bit rate. Each bit is decided by a majority vote of three samples around the bit centre. The result is held so that it is settled well before the rising edge of the recovered clock, which is where a consumer latches it. The recovered clock is also driven on a second pin, meant for an interrupt-style input of a host.

One configuration input selects the mode. When it is low, recovery runs. When it is high, the loop is parked, both clock outputs stay low, and the data output simply follows the synchronised input. A lock flag reports that the recent input transitions are landing where the loop expects them.

Top module: `bit_clk_recovery`

## Requirements
- R1: While `clk_dis` is 1, `bclk_out`, `irq_clk_out` and `locked` are 0 from the second cycle of the disabled state onward, and also after reset.
- R2: While `clk_dis` is 1, `data_out` equals the value `rx_raw` had two clock cycles earlier (a two-stage synchroniser, no filtering).
- R3: While `clk_dis` is 0, `data_out` does not change in the cycle in which `bclk_out` rises, so the consumer can latch it on that rising edge.
- R4: Each recovered bit is the majority of three consecutive samples around the bit centre, so a single inverted sample in mid-bit does not change the recovered bit.
- R5: At the nominal rate and at ±2 % rate error, `locked` is 1 by the end of a 24-bit alternating preamble that starts at any phase relative to the enable.
- R6: With the input rate off by up to ±2 %, every payload bit sent after the preamble appears once, in order, on `data_out` at the rising edges of `bclk_out`.
- R7: `irq_clk_out` always carries the same value as `bclk_out`.
- R8: With clocking enabled and no input transitions, `bclk_out` free-runs with a period of 16 cycles: 8 cycles high and 8 cycles low.
- R9: `locked` rises only after 8 consecutive input transitions fall within ±2 samples of the expected bit boundary, and any transition outside that window clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 16 times the nominal bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_dis | input | 1 | 1 turns recovery off (raw bypass); 0 turns it on |
| rx_raw | input | 1 | Asynchronous demodulated bit stream |
| data_out | output | 1 | Regenerated bit (enabled) or synchronised raw input (disabled) |
| bclk_out | output | 1 | Recovered bit clock; data is valid at its rising edge |
| irq_clk_out | output | 1 | Copy of the recovered clock for an interrupt-style pin |
| locked | output | 1 | Loop has seen 8 consecutive transitions near the expected boundary |

## Verification
The bench drives fractional bit periods of 15.68, 16 and 16.32 samples from several starting phases. A loop whose correction step was wrong, or too small, would slip a bit or repeat one, and the recovered payload would then fail to line up with the sent payload behind a known marker byte. A single inverted sample placed in mid-bit targets the vote: a design that took the centre sample alone would flip that bit. The same glitch must also clear the lock flag, and a lock counter that ignored out-of-window transitions would keep it set. The bench also checks the bypass delay, the timing of data against the clock edge, and the free-running clock with no input transitions. Any off-by-one in the pipeline or the phase wrap shows up there as a wrong delay, a change at the rising edge, or a wrong high time.

// File: rtl/bcr_pkg.sv
// Shared definitions for the bit clock and data recovery block.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bcr_pkg;

    // How far the phase counter moves in one sample cycle.
    typedef enum logic [1:0] {
        ADV_HOLD = 2'd0,   // retard: transition arrived early in the bit
        ADV_ONE  = 2'd1,   // nominal step
        ADV_TWO  = 2'd2    // advance: transition arrived late in the bit
    } adv_e;

    // Two-out-of-three vote.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/bcr_sync.sv
// Input synchroniser and transition detector.
// Brings the asynchronous bit stream into the sample clock domain through
// STAGES flops and flags every change of the synchronised value.
// Assumes STAGES >= 2.
module bcr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_raw,
    output logic rx_s,
    output logic edge_seen
);

    logic [STAGES-1:0] sr;
    logic              prev;

    // Purpose: shift the raw input through the synchroniser and keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            prev <= 1'b0;
        end else begin
            sr   <= {sr[STAGES-2:0], rx_raw};
            prev <= sr[STAGES-1];
        end
    end

    assign rx_s      = sr[STAGES-1];
    assign edge_seen = rx_s ^ prev;

endmodule

// File: rtl/bcr_phase.sv
// Digital phase loop, bit clock generator and lock detector.
// A phase counter counts OSR samples per bit, with phase 0 the expected
// bit boundary. A transition seen in the first half of the bit holds the
// counter for one cycle, and one seen in the second half steps it by two,
// so each transition pulls the loop one sample toward it. The counter
// emits a centre strobe for the vote and drives the clock high for the
// first half of the bit. Assumes OSR >= 8 and LOCK_WIN < OSR/2.
module bcr_phase #(
    parameter int OSR        = 16,
    parameter int LOCK_EDGES = 8,
    parameter int LOCK_WIN   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic edge_seen,
    output logic strobe,
    output logic bclk,
    output logic locked
);
    import bcr_pkg::*;

    localparam int PW = $clog2(OSR);
    localparam int CW = $clog2(LOCK_EDGES + 1);
    localparam logic [PW-1:0] C_CTR   = PW'(OSR / 2);
    localparam logic [PW-1:0] C_STB   = PW'(OSR / 2 + 1);
    localparam logic [PW-1:0] C_LAST  = PW'(OSR - 1);
    localparam logic [PW-1:0] C_WLO   = PW'(LOCK_WIN);
    localparam logic [PW-1:0] C_WHI   = PW'(OSR - LOCK_WIN);
    localparam logic [PW:0]   C_OSRW  = (PW+1)'(OSR);
    localparam logic [CW-1:0] C_LMAX  = CW'(LOCK_EDGES);
    localparam logic [CW-1:0] C_LARM  = CW'(LOCK_EDGES - 1);

    logic [PW-1:0] ph, ph_nxt;
    logic [PW:0]   ph_two;
    logic [CW-1:0] cnt;
    adv_e          adv;
    logic          in_win;

    // Purpose: choose the phase step from where the last transition landed.
    always_comb begin
        if (!edge_seen || ph == '0) adv = ADV_ONE;
        else if (ph <= C_CTR)       adv = ADV_HOLD;
        else                        adv = ADV_TWO;
    end

    // Purpose: next phase, wrapping modulo OSR.
    always_comb begin
        ph_two = {1'b0, ph} + (PW+1)'(2);
        if (ph_two >= C_OSRW) ph_two = ph_two - C_OSRW;
        case (adv)
            ADV_HOLD: ph_nxt = ph;
            ADV_TWO:  ph_nxt = ph_two[PW-1:0];
            default:  ph_nxt = (ph == C_LAST) ? '0 : ph + 1'b1;
        endcase
    end

    assign in_win = (ph <= C_WLO) || (ph >= C_WHI);
    assign strobe = en && (ph == C_STB);

    // Purpose: phase register and registered bit clock (high in first half-bit).
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ph   <= '0;
            bclk <= 1'b0;
        end else begin
            ph   <= ph_nxt;
            bclk <= (ph_nxt < C_CTR);
        end
    end

    // Purpose: count consecutive in-window transitions and raise lock.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else if (edge_seen) begin
            if (in_win) begin
                if (cnt != C_LMAX) cnt <= cnt + 1'b1;
                locked <= (cnt >= C_LARM);
            end else begin
                cnt    <= '0;
                locked <= 1'b0;
            end
        end
    end

    // R8: with no transition the phase steps by exactly one sample.
    p_free_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(edge_seen)) |->
            (($past(ph) == C_LAST) ? (ph == '0) : (ph == $past(ph) + 1'b1)));

    // R9: lock can only rise straight after a transition.
    p_lock_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(edge_seen));

endmodule

// File: rtl/bcr_vote.sv
// Centre-of-bit majority decision.
// Keeps the two previous synchronised samples. On the strobe, one sample
// past the bit centre, it registers the majority of those two and the
// current sample. Assumes the strobe comes once per bit.
module bcr_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_s,
    input  logic strobe,
    output logic bit_q
);
    import bcr_pkg::*;

    logic [1:0] hist;

    // Purpose: sample history and voted bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist  <= '0;
            bit_q <= 1'b0;
        end else begin
            hist <= {hist[0], rx_s};
            if (strobe) bit_q <= maj3(hist[1], hist[0], rx_s);
        end
    end

    // R4: the decided bit only moves on a centre strobe.
    p_vote_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_q) |-> $past(strobe));

endmodule

// File: rtl/bit_clk_recovery.sv
// Bit clock and data recovery, top level.
// Synchronises the demodulated stream, runs the phase loop and the vote,
// and selects between the regenerated data with its clock (clk_dis = 0)
// and a plain synchronised bypass with the clocks held low (clk_dis = 1).
// Assumes clk runs at OSR times the nominal bit rate and clk_dis changes
// synchronously to clk.
module bit_clk_recovery #(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_EDGES  = 8,
    parameter int LOCK_WIN    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_dis,
    input  logic rx_raw,
    output logic data_out,
    output logic bclk_out,
    output logic irq_clk_out,
    output logic locked
);

    logic en, rx_s, edge_seen, strobe, bclk, bit_q;
    logic [1:0] age;

    assign en = !clk_dis;

    bcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw),
        .rx_s(rx_s), .edge_seen(edge_seen)
    );

    bcr_phase #(.OSR(OSR), .LOCK_EDGES(LOCK_EDGES), .LOCK_WIN(LOCK_WIN)) u_phase (
        .clk(clk), .rst_n(rst_n), .en(en), .edge_seen(edge_seen),
        .strobe(strobe), .bclk(bclk), .locked(locked)
    );

    bcr_vote u_vote (
        .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .strobe(strobe), .bit_q(bit_q)
    );

    assign data_out    = en ? bit_q : rx_s;
    assign bclk_out    = bclk;
    assign irq_clk_out = bclk;

    // Purpose: cycles since reset, saturating, to qualify history-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n)            age <= 2'd0;
        else if (age != 2'd3)  age <= age + 2'd1;
    end

    // R1: clocks and lock are quiet once disabled for a cycle.
    p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && clk_dis && $past(clk_dis)) |->
            (!bclk_out && !irq_clk_out && !locked));

    // R2: bypass is the input delayed by the synchroniser.
    p_bypass_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && SYNC_STAGES == 2 && clk_dis) |-> (data_out == $past(rx_raw, 2)));

    // R3: data holds still across the rising clock edge.
    p_stable_at_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !clk_dis && !$past(clk_dis) && bclk_out && !$past(bclk_out))
            |-> $stable(data_out));

endmodule

// File: tb/sim_bit_clk_recovery.sv
module sim_bit_clk_recovery;

    logic clk = 1'b0;
    logic rst_n, clk_dis, rx_raw;
    logic data_out, bclk_out, irq_clk_out, locked;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    bit_clk_recovery u0 (
        .clk(clk), .rst_n(rst_n), .clk_dis(clk_dis), .rx_raw(rx_raw),
        .data_out(data_out), .bclk_out(bclk_out),
        .irq_clk_out(irq_clk_out), .locked(locked)
    );

    always #5 clk = ~clk;

    localparam logic [7:0] MARK = 8'hE7;
    localparam int NPAY = 40;

    bit   rec [0:255];
    int   nrec;
    bit   pay [0:NPAY-1];
    bit   collect;
    bit   bclk_prev, dprev;
    int   r3_bad, r7_bad;
    int   per, pos;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // One sample cycle; samples outputs at the falling edge.
    task automatic tick();
        @(negedge clk);
        if (collect) begin
            if (bclk_out && !bclk_prev) begin
                if (nrec < 256) rec[nrec] = data_out;
                nrec++;
                if (data_out != dprev) r3_bad++;
            end
            if (irq_clk_out != bclk_out) r7_bad++;
        end
        bclk_prev = bclk_out;
        dprev     = data_out;
    endtask

    // Send one bit lasting a fractional number of samples (per in 1/100 sample).
    task automatic send_bit(input bit b, input bit glitch);
        int n;
        n = ((pos + per) / 100) - (pos / 100);
        pos += per;
        for (int k = 0; k < n; k++) begin
            rx_raw = (glitch && k == n / 2) ? ~b : b;
            tick();
        end
    endtask

    // Position just past the marker in the recovered stream, or -1.
    function automatic int find_mark();
        for (int i = 7; i < nrec && i < 256; i++) begin
            logic [7:0] w;
            for (int k = 0; k < 8; k++) w[7-k] = rec[i-7+k];
            if (w == MARK) return i + 1;
        end
        return -1;
    endfunction

    // Payload bits that do not match the recovered stream from start.
    function automatic int pay_mismatch(input int start);
        int m = 0;
        for (int j = 0; j < NPAY; j++)
            if (start + j >= 256 || start + j >= nrec || rec[start+j] != pay[j]) m++;
        return m;
    endfunction

    task automatic run_trial(input int period, input int off, input bit glitch);
        int st, mm;
        clk_dis = 1'b1;
        rx_raw  = 1'b0;
        repeat (4) tick();
        chk(!bclk_out && !irq_clk_out && !locked, "R1 disabled outputs quiet", {bclk_out, irq_clk_out, locked}, 0);
        per = period; pos = 0; nrec = 0; r3_bad = 0; r7_bad = 0;
        clk_dis = 1'b0;
        collect = 1'b1;
        repeat (off) tick();
        for (int i = 0; i < 24; i++) begin
            send_bit(i % 2 == 0, 1'b0);
            if (i == 5) chk(!locked, "R9 no lock before 8 edges", locked, 0);
        end
        chk(locked, "R5 locked after 24-bit preamble", locked, 1);
        for (int i = 7; i >= 0; i--) send_bit(MARK[i], 1'b0);
        for (int j = 0; j < NPAY; j++) begin
            if (glitch && (j % 8) >= 4 && (j % 8) <= 6 && j > 0) pay[j] = ~pay[j-1];
            else pay[j] = 1'($urandom % 2);
            send_bit(pay[j], glitch && (j % 8 == 2));
            if (glitch && j == 2) chk(!locked, "R9 lock cleared by mid-bit transition", locked, 0);
        end
        for (int i = 0; i < 8; i++) send_bit(i % 2 == 0, 1'b0);
        collect = 1'b0;
        st = find_mark();
        chk(st >= 0, "R6 marker recovered", st, 1);
        mm = pay_mismatch(st < 0 ? 0 : st);
        if (glitch) chk(mm == 0, "R4 payload with single-sample glitches", mm, 0);
        else        chk(mm == 0, "R6 payload under rate error", mm, 0);
        chk(r3_bad == 0, "R3 data stable at rising clock", r3_bad, 0);
        chk(r7_bad == 0, "R7 irq clock mirrors bit clock", r7_bad, 0);
    endtask

    initial begin
        bit hist [0:2];
        int highs, rises;
        bit pv;
        void'($urandom(32'd1234));
        rst_n = 1'b0; clk_dis = 1'b0; rx_raw = 1'b0; collect = 1'b0;
        bclk_prev = 1'b0; dprev = 1'b0;
        repeat (4) tick();
        chk(!bclk_out && !irq_clk_out && !locked, "R1 reset state", {bclk_out, irq_clk_out, locked}, 0);
        rst_n = 1'b1;

        // R2: bypass follows input two cycles late.
        clk_dis = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (i >= 2) chk(data_out == hist[2 - 2 + 0], "R2 bypass delay", data_out, hist[0]);
            hist[0] = hist[1];
            hist[1] = 1'($urandom % 2);
            rx_raw  = hist[1];
            tick();
        end
        chk(!bclk_out && !locked, "R1 no clock in bypass", bclk_out, 0);

        run_trial(1600, 3,  1'b0);
        run_trial(1568, 11, 1'b0);
        run_trial(1632, 7,  1'b0);
        run_trial(1600, 5,  1'b1);

        // R8: free-running clock with a constant input.
        clk_dis = 1'b1; rx_raw = 1'b1; repeat (4) tick();
        clk_dis = 1'b0; repeat (20) tick();
        highs = 0; rises = 0; pv = bclk_out;
        for (int i = 0; i < 160; i++) begin
            tick();
            if (bclk_out) highs++;
            if (bclk_out && !pv) rises++;
            pv = bclk_out;
        end
        chk(highs == 80, "R8 clock high time", highs, 80);
        chk(rises == 10, "R8 clock period", rises, 10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule